// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the address reservations that hardware contexts take with load-reserved operations, and it rules on every write that reaches memory. A load-reserved names a context and an address. The block stores the address's 64-byte line for that context. A context never holds more than one reservation, so a later load-reserved from the same context moves its existing reservation to the new line.

Each write presents a context, an address and a conditional flag. A plain store always succeeds. A store-conditional succeeds only when the writer still holds a reservation on that exact line. Once any write succeeds, every reservation on the written line is dropped, whoever owns it. Each owner other than the writer receives a one-cycle clear-exclusive pulse on its own bit of a per-context vector. A store-conditional that fails changes nothing.

The table has a fixed number of slots. When a load-reserved needs a new slot and none is free, the block overwrites the slot under a round-robin pointer. A small state machine sequences the reply. In state PH_IDLE no result is presented. Any write strobe moves it to PH_REPLY, where the result and the clear-exclusive vector are valid for exactly one cycle. From PH_REPLY it returns to PH_IDLE, unless another write strobe arrives, in which case it stays in PH_REPLY.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation exists. `rsp_valid` is 0, `clr_excl` is all zeros, and a store-conditional issued straight after reset fails.
- R2: A load-reserved from a context with no reservation allocates one. A following store-conditional from that context to the same line returns `rsp_ok`=1.
- R3: A load-reserved from a context that already holds a reservation moves that reservation to the new line. A store-conditional to the old line then fails, and one to the new line succeeds.
- R4: Address bits [5:0] are ignored on store and on compare. A reservation taken at 0x1000 matches a write to 0x103C, but not a write to 0x1040.
- R5: A write with `wr_cond`=0 always returns `rsp_ok`=1.
- R6: A store-conditional fails when no reservation matches both its context and its line, even if another context holds that line.
- R7: A failed store-conditional removes no reservation and raises no `clr_excl` bit.
- R8: A successful write removes every reservation on its line. Reservations on other lines are kept.
- R9: For every reservation that a write removes, `clr_excl[c]` pulses, where c is the owning context, unless c is the writer's own context.
- R10: If a new reservation is needed and every slot is taken, the slot under a round-robin pointer is overwritten without any `clr_excl` pulse. The pointer starts at slot 0 after reset and advances by one on each such overwrite. Free slots are filled lowest index first.
- R11: `rsp_valid` is 1 exactly in the cycle after each `wr_valid` cycle and at no other time. `clr_excl` is nonzero only while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserved strobe; never in the same cycle as wr_valid |
| lr_ctx | input | 4 | Context taking the reservation |
| lr_addr | input | 32 | Load-reserved byte address |
| wr_valid | input | 1 | Write-check strobe |
| wr_ctx | input | 4 | Writing context |
| wr_addr | input | 32 | Write byte address |
| wr_cond | input | 1 | 1 = store-conditional, 0 = plain store |
| rsp_valid | output | 1 | Result valid, one cycle after wr_valid |
| rsp_ok | output | 1 | 1 = write allowed / store-conditional succeeded |
| clr_excl | output | 16 | One bit per context; pulses when that context loses its reservation to another writer |

## Verification
A successful store-conditional has two effects in the same result cycle: it grants success to the writer, and it revokes the reservations that other contexts hold on the same line. The bench provokes this by having two or three contexts reserve one line and then issuing a store-conditional from one of them. It expects `rsp_ok`=1 and a `clr_excl` vector with exactly the other owners' bits set. It then confirms at the ports that those owners' store-conditionals fail. A second collision happens when a load-reserved both misses the table and finds it full, so that allocation and eviction coincide. The bench fills all slots and then checks which older contexts lost their reservations.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Reply sequencing states
    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_REPLY = 1'b1
    } phase_e;

endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
    parameter int CTX_W  = 4,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CTX_W-1:0]  load_ctx,
    input  logic [LINE_W-1:0] load_line,
    input  logic              kill,
    output logic              valid,
    output logic [CTX_W-1:0]  ctx,
    output logic [LINE_W-1:0] line
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ctx   <= '0;
            line  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            ctx   <= load_ctx;
            line  <= load_line;
        end else if (kill) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] occupied,
    input  logic               advance,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // lowest-index free slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_idx <= '0;
        end else if (advance) begin
            rr_idx <= (rr_idx == LAST) ? '0 : rr_idx + 1'b1;
        end
    end

    // R10: pointer only moves when the table is full
    assert_advance_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !free_any);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ENTRIES = 8,
    parameter int CTX_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int GRAIN_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lr_valid,
    input  logic [CTX_W-1:0]       lr_ctx,
    input  logic [ADDR_W-1:0]      lr_addr,
    input  logic                   wr_valid,
    input  logic [CTX_W-1:0]       wr_ctx,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic                   wr_cond,
    output logic                   rsp_valid,
    output logic                   rsp_ok,
    output logic [(1<<CTX_W)-1:0]  clr_excl
);
    import llsc_pkg::*;

    localparam int LINE_W = ADDR_W - GRAIN_W;
    localparam int NCTX   = 1 << CTX_W;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // line addresses: low grain bits dropped
    logic [LINE_W-1:0] lr_line, wr_line;
    assign lr_line = lr_addr[ADDR_W-1:GRAIN_W];
    assign wr_line = wr_addr[ADDR_W-1:GRAIN_W];
    logic unused_grain_bits;
    assign unused_grain_bits = ^{lr_addr[GRAIN_W-1:0], wr_addr[GRAIN_W-1:0]};

    // slot state
    logic [ENTRIES-1:0] ent_v;
    logic [CTX_W-1:0]   ent_ctx  [ENTRIES];
    logic [LINE_W-1:0]  ent_line [ENTRIES];
    logic [ENTRIES-1:0] ent_load, ent_kill;

    logic [ENTRIES-1:0] lr_ctx_hit, wr_line_hit, wr_own_hit;
    logic               write_ok;

    logic               free_any, replace;
    logic [IDX_W-1:0]   free_idx, rr_idx, hit_idx, tgt_idx;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            llsc_slot #(.CTX_W(CTX_W), .LINE_W(LINE_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (ent_load[gi]),
                .load_ctx  (lr_ctx),
                .load_line (lr_line),
                .kill      (ent_kill[gi]),
                .valid     (ent_v[gi]),
                .ctx       (ent_ctx[gi]),
                .line      (ent_line[gi])
            );
            assign lr_ctx_hit[gi]  = ent_v[gi] && (ent_ctx[gi] == lr_ctx);
            assign wr_line_hit[gi] = ent_v[gi] && (ent_line[gi] == wr_line);
            assign wr_own_hit[gi]  = wr_line_hit[gi] && (ent_ctx[gi] == wr_ctx);
            assign ent_load[gi]    = lr_valid && (tgt_idx == IDX_W'(gi));
            assign ent_kill[gi]    = wr_valid && write_ok && wr_line_hit[gi];
        end
    endgenerate

    llsc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .occupied (ent_v),
        .advance  (replace),
        .free_any (free_any),
        .free_idx (free_idx),
        .rr_idx   (rr_idx)
    );

    // plain store always allowed; conditional needs (ctx, line) match
    assign write_ok = !wr_cond || (|wr_own_hit);

    // load-reserved target selection: own slot, else free slot, else victim
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lr_ctx_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        replace = 1'b0;
        if (|lr_ctx_hit) begin
            tgt_idx = hit_idx;
        end else if (free_any) begin
            tgt_idx = free_idx;
        end else begin
            tgt_idx = rr_idx;
            replace = lr_valid;
        end
    end

    // clear-exclusive vector for other owners of removed slots
    logic [NCTX-1:0] clr_d;
    always_comb begin
        clr_d = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_kill[i] && (ent_ctx[i] != wr_ctx)) clr_d[ent_ctx[i]] = 1'b1;
        end
    end

    // reply state machine
    phase_e phase_q, phase_d;

    always_comb begin
        unique case (phase_q)
            PH_IDLE:  phase_d = wr_valid ? PH_REPLY : PH_IDLE;
            PH_REPLY: phase_d = wr_valid ? PH_REPLY : PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok   <= 1'b0;
            clr_excl <= '0;
        end else if (wr_valid) begin
            rsp_ok   <= write_ok;
            clr_excl <= clr_d;
        end else begin
            rsp_ok   <= 1'b0;
            clr_excl <= '0;
        end
    end

    assign rsp_valid = (phase_q == PH_REPLY);

    // ---------------- assertions ----------------
    assert_rsp_after_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> rsp_valid);
    assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !rsp_valid);
    assert_clr_only_in_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (clr_excl == '0));
    assert_plain_store_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_cond) |=> rsp_ok);
    assert_failed_sc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (clr_excl == '0));
    assert_no_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !clr_excl[$past(wr_ctx)]);
    assert_failed_sc_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !write_ok) |=> (ent_v == $past(ent_v)));

    generate
        for (gi = 0; gi < NCTX; gi++) begin : g_ctx_chk
            logic [ENTRIES-1:0] holds;
            for (genvar gj = 0; gj < ENTRIES; gj++) begin : g_bit
                assign holds[gj] = ent_v[gj] && (ent_ctx[gj] == CTX_W'(gi));
            end
            assert_one_per_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(holds));
        end
    endgenerate

endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;

    localparam int CTX_W = 4;
    localparam int NCTX  = 1 << CTX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lr_valid = 1'b0;
    logic [3:0]      lr_ctx = '0;
    logic [31:0]     lr_addr = '0;
    logic            wr_valid = 1'b0;
    logic [3:0]      wr_ctx = '0;
    logic [31:0]     wr_addr = '0;
    logic            wr_cond = 1'b0;
    logic            rsp_valid, rsp_ok;
    logic [NCTX-1:0] clr_excl;

    always #2.5 clk = ~clk;

    llsc_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_ctx(lr_ctx), .lr_addr(lr_addr),
        .wr_valid(wr_valid), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_cond(wr_cond),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .clr_excl(clr_excl)
    );

    typedef struct {
        int              due;
        logic            ok;
        logic [NCTX-1:0] clr;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: scoreboard pops expected replies in their due cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (!rsp_valid || rsp_ok !== e.ok || clr_excl !== e.clr) begin
                    n_fail++;
                    $display("FAIL %s: valid=%0b ok=%0b clr=%h, expected valid=1 ok=%0b clr=%h",
                             e.tag, rsp_valid, rsp_ok, clr_excl, e.ok, e.clr);
                end
            end else if (rsp_valid || clr_excl != '0) begin
                n_run++;
                n_fail++;
                $display("FAIL R11: unexpected valid=%0b clr=%h, expected valid=0 clr=0",
                         rsp_valid, clr_excl);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reserve(input int c, input logic [31:0] a);
        @(negedge clk);
        lr_valid = 1'b1; lr_ctx = 4'(c); lr_addr = a;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    task automatic write(input int c, input logic [31:0] a, input logic cond,
                         input logic ok, input logic [NCTX-1:0] clr, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = 1'b1; wr_ctx = 4'(c); wr_addr = a; wr_cond = cond;
        e.due = cyc + 1; e.ok = ok; e.clr = clr; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        n_run++;
        if (rsp_valid !== 1'b0 || clr_excl !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b clr=%h, expected 0/0", rsp_valid, clr_excl);
        end
        write(1, 32'h0000_1000, 1, 0, '0, "R1 sc after reset");

        // R2 allocate and succeed
        reserve(1, 32'h0000_2000);
        write(1, 32'h0000_2000, 1, 1, '0, "R2 sc own line");
        write(1, 32'h0000_2000, 1, 0, '0, "R8 reservation consumed");

        // R3 replace
        reserve(2, 32'h0000_3000);
        reserve(2, 32'h0000_4000);
        write(2, 32'h0000_3000, 1, 0, '0, "R3 old line dropped");
        write(2, 32'h0000_4000, 1, 1, '0, "R3 new line held");

        // R4 granularity
        reserve(3, 32'h0000_1000);
        write(3, 32'h0000_1040, 1, 0, '0, "R4 next line");
        write(3, 32'h0000_103C, 1, 1, '0, "R4 same line");

        // R5 plain store with no reservation
        write(7, 32'h0000_9000, 0, 1, '0, "R5 plain store");

        // R6 / R7 wrong context
        reserve(4, 32'h0000_5000);
        write(5, 32'h0000_5000, 1, 0, '0, "R6 other ctx sc");
        write(4, 32'h0000_5000, 1, 1, '0, "R7 reservation survived");

        // R8 / R9 plain store clears all owners, other lines kept
        reserve(1, 32'h0000_6000);
        reserve(3, 32'h0000_6010);
        reserve(6, 32'h0000_7000);
        write(5, 32'h0000_6020, 0, 1, 16'h000A, "R9 store clears 1 and 3");
        write(1, 32'h0000_6000, 1, 0, '0, "R8 ctx1 removed");
        write(3, 32'h0000_6000, 1, 0, '0, "R8 ctx3 removed");
        write(6, 32'h0000_7000, 1, 1, '0, "R8 other line kept");

        // R9 successful sc: writer not signalled, others are
        reserve(1, 32'h0000_8000);
        reserve(2, 32'h0000_8000);
        reserve(9, 32'h0000_8000);
        write(1, 32'h0000_8004, 1, 1, 16'h0204, "R9 sc clears 2 and 9");
        write(2, 32'h0000_8000, 1, 0, '0, "R8 ctx2 removed by sc");

        // R10 round-robin replacement on a fresh table
        do_reset();
        for (int c = 0; c < 8; c++) reserve(c, 32'h0001_0000 + 32'(c) * 32'h40);
        reserve(8, 32'h0002_0000);
        reserve(9, 32'h0002_0040);
        write(0, 32'h0001_0000, 1, 0, '0, "R10 slot0 evicted");
        write(1, 32'h0001_0040, 1, 0, '0, "R10 slot1 evicted");
        write(2, 32'h0001_0080, 1, 1, '0, "R10 slot2 kept");
        write(8, 32'h0002_0000, 1, 1, '0, "R10 ctx8 held");
        write(9, 32'h0002_0040, 1, 1, '0, "R10 ctx9 held");

        repeat (4) @(negedge clk);
        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d replies missing, expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule